// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Tracking and Monitor Select

This block holds two digital phase/frequency comparators, one for a low-band loop (channel 0) and one for a high-band loop (channel 1). Both run in a single reference-clock domain. Each comparator watches the rising edges of its reference-divider pulse and its feedback-divider pulse. It drives a tri-state pump command, presented as separate drive-high, drive-low and enable signals, and a polarity bit per channel selects which direction is driven. The width of each phase error is counted in clock cycles. A per-channel lock tracker uses that width to decide lock.

A combined lock flag reports that both loops are settled. A channel in power-save counts as settled. One monitor output carries either this combined flag or one of the four raw divider pulses, chosen by three select inputs. A per-channel sleep input silences the pump command and clears the lock tracker. On wake-up, the first error pulse is capped so that the oscillator does not jump far.

Top module: `pfd_dual_lockmon`

## Requirements
- R1: When the reference edge arrives first and the feedback edge comes w cycles later (or the feedback edge arrives first and the reference edge comes w cycles later), the channel drives one pump level for exactly w cycles. A leading reference drives high when the polarity bit is 1 and low when it is 0. A lagging reference drives the opposite level. The enable is high for exactly those cycles.
- R2: Reference and feedback edges seen in the same cycle give a one-cycle pulse with drive-high, drive-low and enable all set (dead-zone pulse). Such a comparison has an error width of 0.
- R3: A second reference edge that arrives while the reference already leads keeps the drive active until the feedback edge. The error saturates at one full cycle and does not restart. That comparison counts as a large error.
- R4: A finished comparison whose error is 2 cycles or more, or which saturated, clears the channel's lock and its run count.
- R5: A channel becomes locked only when 3 consecutive finished comparisons each have an error below 2 cycles.
- R6: `lock_all` is 1 exactly when each channel is either locked or asleep.
- R7: While a channel's sleep input is 1, its pump outputs stay 0 and its lock and run count are cleared. After wake-up, lock needs 3 fresh good comparisons.
- R8: The first error pulse after a channel wakes is limited to 4 drive cycles. Later pulses are not limited.
- R9: With `mon_mode`=0, `mon_out` follows the combined lock flag. With `mon_mode`=1, `mon_band` picks channel 0 (value 0) or channel 1 (value 1), and `mon_src` picks the reference pulse (value 0) or the feedback pulse (value 1). The chosen signal appears one cycle later.
- R10: After reset, all pump outputs, `lock_all` and `mon_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_ch0 | input | 1 | Reference-divider pulse, channel 0 |
| fb_ch0 | input | 1 | Feedback-divider pulse, channel 0 |
| sleep_ch0 | input | 1 | Power-save, channel 0 |
| pol_ch0 | input | 1 | Pump polarity, channel 0 |
| ref_ch1 | input | 1 | Reference-divider pulse, channel 1 |
| fb_ch1 | input | 1 | Feedback-divider pulse, channel 1 |
| sleep_ch1 | input | 1 | Power-save, channel 1 |
| pol_ch1 | input | 1 | Pump polarity, channel 1 |
| mon_mode | input | 1 | 0: lock flag, 1: divider pulse |
| mon_band | input | 1 | Monitored channel |
| mon_src | input | 1 | 0: reference pulse, 1: feedback pulse |
| pump_hi_ch0 | output | 1 | Drive-high command, channel 0 |
| pump_lo_ch0 | output | 1 | Drive-low command, channel 0 |
| pump_en_ch0 | output | 1 | Pump enable, channel 0 |
| pump_hi_ch1 | output | 1 | Drive-high command, channel 1 |
| pump_lo_ch1 | output | 1 | Drive-low command, channel 1 |
| pump_en_ch1 | output | 1 | Pump enable, channel 1 |
| lock_all | output | 1 | Combined lock flag |
| mon_out | output | 1 | Monitor output |

## Verification
The bench builds the block with its default parameters: an 8-bit width counter, a 2-cycle error threshold, a 3-comparison lock run and a 4-cycle wake clamp. With these small thresholds, a sweep of edge offsets from -6 to +6 under both polarities crosses the lock threshold, the run length and the clamp in a few hundred cycles. It also checks every polarity/direction pairing. An exhaustive 4-by-4 sweep of monitor selects against single active pulses covers all routes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LAG  = 2'd2
  } pfd_phase_e;
endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
  import pfd_pkg::*;
#(
  parameter int WIDTH_W = 8,
  parameter int CLAMP_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_i,
  input  logic               fb_i,
  input  logic               sleep_i,
  input  logic               pol_i,
  output logic               pump_hi_o,
  output logic               pump_lo_o,
  output logic               pump_en_o,
  output logic               done_o,
  output logic               bad_o,
  output logic [WIDTH_W-1:0] width_o
);
  localparam logic [WIDTH_W-1:0] CNT_MAX = '1;
  localparam logic [WIDTH_W-1:0] CLAMP_V = WIDTH_W'(CLAMP_W);
  localparam logic [WIDTH_W-1:0] ONE_V   = WIDTH_W'(1);

  logic ref_q, fb_q;
  logic ref_rise, fb_rise;
  pfd_phase_e state, state_n;
  logic [WIDTH_W-1:0] cnt, cnt_n, width_n;
  logic sat, sat_n, wake, wake_n;
  logic done_n, bad_n, dz_n;
  logic lead_n, lag_n, limit_n, hi_n, lo_n;

  assign ref_rise = ref_i & ~ref_q;
  assign fb_rise  = fb_i & ~fb_q;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sat_n   = sat;
    wake_n  = wake;
    done_n  = 1'b0;
    bad_n   = 1'b0;
    dz_n    = 1'b0;
    width_n = width_o;
    if (sleep_i) begin
      state_n = PH_IDLE;
      cnt_n   = '0;
      sat_n   = 1'b0;
      wake_n  = 1'b1;
    end else begin
      unique case (state)
        PH_IDLE: begin
          if (ref_rise && fb_rise) begin
            done_n  = 1'b1;
            width_n = '0;
            dz_n    = 1'b1;
            wake_n  = 1'b0;
          end else if (ref_rise) begin
            state_n = PH_LEAD;
            cnt_n   = ONE_V;
            sat_n   = 1'b0;
          end else if (fb_rise) begin
            state_n = PH_LAG;
            cnt_n   = ONE_V;
            sat_n   = 1'b0;
          end
        end
        PH_LEAD: begin
          if (fb_rise) begin
            done_n  = 1'b1;
            width_n = cnt;
            bad_n   = sat;
            wake_n  = 1'b0;
            sat_n   = 1'b0;
            if (ref_rise) begin
              cnt_n = ONE_V;
            end else begin
              state_n = PH_IDLE;
              cnt_n   = '0;
            end
          end else begin
            if (ref_rise) sat_n = 1'b1;
            cnt_n = (cnt == CNT_MAX) ? cnt : cnt + ONE_V;
          end
        end
        PH_LAG: begin
          if (ref_rise) begin
            done_n  = 1'b1;
            width_n = cnt;
            bad_n   = sat;
            wake_n  = 1'b0;
            sat_n   = 1'b0;
            if (fb_rise) begin
              cnt_n = ONE_V;
            end else begin
              state_n = PH_IDLE;
              cnt_n   = '0;
            end
          end else begin
            if (fb_rise) sat_n = 1'b1;
            cnt_n = (cnt == CNT_MAX) ? cnt : cnt + ONE_V;
          end
        end
        default: begin
          state_n = PH_IDLE;
          cnt_n   = '0;
        end
      endcase
    end
  end

  assign lead_n  = (state_n == PH_LEAD);
  assign lag_n   = (state_n == PH_LAG);
  assign limit_n = wake_n && (cnt_n > CLAMP_V);
  assign hi_n    = dz_n | (~limit_n & (pol_i ? lead_n : lag_n));
  assign lo_n    = dz_n | (~limit_n & (pol_i ? lag_n : lead_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= 1'b0;
      fb_q      <= 1'b0;
      state     <= PH_IDLE;
      cnt       <= '0;
      sat       <= 1'b0;
      wake      <= 1'b0;
      done_o    <= 1'b0;
      bad_o     <= 1'b0;
      width_o   <= '0;
      pump_hi_o <= 1'b0;
      pump_lo_o <= 1'b0;
      pump_en_o <= 1'b0;
    end else begin
      ref_q     <= ref_i;
      fb_q      <= fb_i;
      state     <= state_n;
      cnt       <= cnt_n;
      sat       <= sat_n;
      wake      <= wake_n;
      done_o    <= done_n;
      bad_o     <= bad_n;
      width_o   <= width_n;
      pump_hi_o <= hi_n;
      pump_lo_o <= lo_n;
      pump_en_o <= hi_n | lo_n;
    end
  end

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (!pump_hi_o && !pump_lo_o)); // R7
  AST_DZ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (pump_hi_o && pump_lo_o) |=> !(pump_hi_o && pump_lo_o)); // R2
  AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (wake && state != PH_IDLE && cnt >= CLAMP_V) |=> !(pump_hi_o ^ pump_lo_o)); // R8
endmodule

// File: rtl/pfd_lock_track.sv
module pfd_lock_track #(
  parameter int WIDTH_W  = 8,
  parameter int DROP_W   = 2,
  parameter int LOCK_RUN = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_i,
  input  logic               done_i,
  input  logic               bad_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               locked_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0]   RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIDTH_W-1:0] DROP_V   = WIDTH_W'(DROP_W);

  logic [RUN_W-1:0] run;
  logic good;

  assign good = !bad_i && (width_i < DROP_V);

  always_ff @(posedge clk) begin
    if (rst || sleep_i) begin
      run      <= '0;
      locked_o <= 1'b0;
    end else if (done_i) begin
      if (!good) begin
        run      <= '0;
        locked_o <= 1'b0;
      end else if (run >= RUN_LAST) begin
        locked_o <= 1'b1;
      end else begin
        run <= run + RUN_W'(1);
      end
    end
  end

  AST_RISE_AFTER_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(done_i && good && run == RUN_LAST)); // R5
  AST_BAD_DROPS: assert property (@(posedge clk) disable iff (rst)
    (done_i && !good) |=> !locked_o); // R4
  AST_SLEEP_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (!locked_o && run == '0)); // R7
endmodule

// File: rtl/pfd_lock_mux.sv
module pfd_lock_mux #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] locked_i,
  input  logic [NCH-1:0] sleep_i,
  input  logic [NCH-1:0] ref_i,
  input  logic [NCH-1:0] fb_i,
  input  logic           mode_i,
  input  logic           band_i,
  input  logic           src_i,
  output logic           lock_all_o,
  output logic           mon_o
);
  logic all_ok, pick;

  assign all_ok = &(locked_i | sleep_i);
  assign pick   = src_i ? fb_i[band_i] : ref_i[band_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_all_o <= 1'b0;
      mon_o      <= 1'b0;
    end else begin
      lock_all_o <= all_ok;
      mon_o      <= mode_i ? pick : all_ok;
    end
  end

  AST_ALL_ASLEEP_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (&sleep_i) |=> lock_all_o); // R6
  AST_MON_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && !(&sleep_i) && !(|locked_i)) |=> !mon_o); // R9
endmodule

// File: rtl/pfd_dual_lockmon.sv
module pfd_dual_lockmon #(
  parameter int WIDTH_W  = 8,
  parameter int DROP_W   = 2,
  parameter int LOCK_RUN = 3,
  parameter int CLAMP_W  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ch0,
  input  logic fb_ch0,
  input  logic sleep_ch0,
  input  logic pol_ch0,
  input  logic ref_ch1,
  input  logic fb_ch1,
  input  logic sleep_ch1,
  input  logic pol_ch1,
  input  logic mon_mode,
  input  logic mon_band,
  input  logic mon_src,
  output logic pump_hi_ch0,
  output logic pump_lo_ch0,
  output logic pump_en_ch0,
  output logic pump_hi_ch1,
  output logic pump_lo_ch1,
  output logic pump_en_ch1,
  output logic lock_all,
  output logic mon_out
);
  localparam int NCH = 2;

  logic [NCH-1:0] ref_v, fb_v, sleep_v, pol_v;
  logic [NCH-1:0] hi_v, lo_v, en_v, done_v, bad_v, locked_v;
  logic [WIDTH_W-1:0] width_v [NCH];

  assign ref_v   = {ref_ch1, ref_ch0};
  assign fb_v    = {fb_ch1, fb_ch0};
  assign sleep_v = {sleep_ch1, sleep_ch0};
  assign pol_v   = {pol_ch1, pol_ch0};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfd_phase_core #(
      .WIDTH_W(WIDTH_W),
      .CLAMP_W(CLAMP_W)
    ) core_i (
      .clk      (clk),
      .rst      (rst),
      .ref_i    (ref_v[g]),
      .fb_i     (fb_v[g]),
      .sleep_i  (sleep_v[g]),
      .pol_i    (pol_v[g]),
      .pump_hi_o(hi_v[g]),
      .pump_lo_o(lo_v[g]),
      .pump_en_o(en_v[g]),
      .done_o   (done_v[g]),
      .bad_o    (bad_v[g]),
      .width_o  (width_v[g])
    );

    pfd_lock_track #(
      .WIDTH_W (WIDTH_W),
      .DROP_W  (DROP_W),
      .LOCK_RUN(LOCK_RUN)
    ) lock_i (
      .clk     (clk),
      .rst     (rst),
      .sleep_i (sleep_v[g]),
      .done_i  (done_v[g]),
      .bad_i   (bad_v[g]),
      .width_i (width_v[g]),
      .locked_o(locked_v[g])
    );
  end

  pfd_lock_mux #(
    .NCH(NCH)
  ) mux_i (
    .clk       (clk),
    .rst       (rst),
    .locked_i  (locked_v),
    .sleep_i   (sleep_v),
    .ref_i     (ref_v),
    .fb_i      (fb_v),
    .mode_i    (mon_mode),
    .band_i    (mon_band),
    .src_i     (mon_src),
    .lock_all_o(lock_all),
    .mon_o     (mon_out)
  );

  assign pump_hi_ch0 = hi_v[0];
  assign pump_lo_ch0 = lo_v[0];
  assign pump_en_ch0 = en_v[0];
  assign pump_hi_ch1 = hi_v[1];
  assign pump_lo_ch1 = lo_v[1];
  assign pump_en_ch1 = en_v[1];
endmodule

// File: tb/pfd_dual_lockmon_tb_top.sv
module pfd_dual_lockmon_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] fr_v = '0, fp_v = '0, sl_v = '0, pol_v = '0;
  logic mon_mode = 1'b0, mon_band = 1'b0, mon_src = 1'b0;
  logic hi0, lo0, en0, hi1, lo1, en1, lock_all, mon_out;

  int checks = 0;
  int errors = 0;
  int mdl_run [2];
  int mdl_lock [2];
  bit finished = 0;

  always #5 clk = ~clk;

  pfd_dual_lockmon dut_i (
    .clk(clk), .rst(rst),
    .ref_ch0(fr_v[0]), .fb_ch0(fp_v[0]), .sleep_ch0(sl_v[0]), .pol_ch0(pol_v[0]),
    .ref_ch1(fr_v[1]), .fb_ch1(fp_v[1]), .sleep_ch1(sl_v[1]), .pol_ch1(pol_v[1]),
    .mon_mode(mon_mode), .mon_band(mon_band), .mon_src(mon_src),
    .pump_hi_ch0(hi0), .pump_lo_ch0(lo0), .pump_en_ch0(en0),
    .pump_hi_ch1(hi1), .pump_lo_ch1(lo1), .pump_en_ch1(en1),
    .lock_all(lock_all), .mon_out(mon_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_lock_all();
    return ((mdl_lock[0] != 0 || sl_v[0]) && (mdl_lock[1] != 0 || sl_v[1])) ? 1 : 0;
  endfunction

  // One comparison window: reference edges at fa (and fa2 if >= 0), feedback edge at fb.
  task automatic run_seq(input int ch, input int fa, input int fa2, input int fb,
                         input int e_hi, input int e_lo, input int e_en, input string tag);
    int n_hi = 0, n_lo = 0, n_en = 0;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      n_hi += (ch == 0) ? int'(hi0) : int'(hi1);
      n_lo += (ch == 0) ? int'(lo0) : int'(lo1);
      n_en += (ch == 0) ? int'(en0) : int'(en1);
      fr_v[ch] = (c == fa || c == fa + 1 || (fa2 >= 0 && (c == fa2 || c == fa2 + 1)));
      fp_v[ch] = (c == fb || c == fb + 1);
    end
    check({tag, " drive-high cycles"}, n_hi, e_hi);
    check({tag, " drive-low cycles"}, n_lo, e_lo);
    check({tag, " enable cycles"}, n_en, e_en);
  endtask

  // Offset d = feedback edge minus reference edge; len = expected drive cycles.
  task automatic cmp(input int ch, input int d, input int len, input string tag);
    int fa, fb, ad, e_hi, e_lo, e_en;
    bit lead;
    ad = (d < 0) ? -d : d;
    fa = 2 + ((d < 0) ? -d : 0);
    fb = 2 + ((d > 0) ? d : 0);
    lead = (d > 0);
    if (d == 0) begin
      e_hi = 1; e_lo = 1; e_en = 1;
    end else begin
      e_hi = (lead == pol_v[ch]) ? len : 0;
      e_lo = (lead == pol_v[ch]) ? 0 : len;
      e_en = len;
    end
    run_seq(ch, fa, -1, fb, e_hi, e_lo, e_en, tag);
    if (ad >= 2) begin
      mdl_run[ch] = 0; mdl_lock[ch] = 0;
    end else begin
      mdl_run[ch]++;
      if (mdl_run[ch] >= 3) mdl_lock[ch] = 1;
    end
    check({tag, " lock after comparison (R4/R5 model) R5"}, int'(lock_all), exp_lock_all());
  endtask

  task automatic set_sleep(input int ch, input bit v);
    @(negedge clk);
    sl_v[ch] = v;
    if (v) begin
      mdl_run[ch] = 0; mdl_lock[ch] = 0;
    end
    idle(4);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mdl_run[0] = 0; mdl_run[1] = 0; mdl_lock[0] = 0; mdl_lock[1] = 0;
    idle(5);
    rst = 1'b0;
    idle(2);
    // R10: reset state
    check("R10 pump ch0", int'({hi0, lo0, en0}), 0);
    check("R10 pump ch1", int'({hi1, lo1, en1}), 0);
    check("R10 lock_all", int'(lock_all), 0);
    check("R10 mon_out", int'(mon_out), 0);

    set_sleep(1, 1'b1);
    check("R6 ch1 asleep, ch0 unlocked", int'(lock_all), 0);

    // R1/R2/R4/R5: offset sweep under both polarities on channel 0
    for (int p = 1; p >= 0; p--) begin
      pol_v[0] = p[0];
      for (int d = -6; d <= 6; d++) begin
        cmp(0, d, (d < 0) ? -d : d, (d == 0) ? "R2" : "R1");
      end
    end

    // R3: second reference edge while leading saturates
    pol_v[0] = 1'b1;
    run_seq(0, 2, 6, 10, 8, 0, 8, "R3");
    mdl_run[0] = 0; mdl_lock[0] = 0;
    check("R3 saturated comparison clears lock R4", int'(lock_all), exp_lock_all());

    // Build lock, then sleep ch0: no drive, combined lock holds through sleep
    cmp(0, 0, 0, "R5"); cmp(0, 1, 1, "R5"); cmp(0, -1, 1, "R5");
    set_sleep(0, 1'b1);
    run_seq(0, 2, -1, 5, 0, 0, 0, "R7 asleep");
    check("R6 both asleep", int'(lock_all), 1);
    set_sleep(0, 1'b0);
    check("R7 lock cleared after wake", int'(lock_all), 0);

    // R8: first pulse after wake clamped, second not
    cmp(0, 6, 4, "R8 first after wake");
    cmp(0, -6, 6, "R8 second after wake");
    cmp(0, 1, 1, "R7 run restarts");
    cmp(0, 0, 0, "R7 run restarts");
    check("R7 two good not locked", int'(lock_all), 0);
    cmp(0, -1, 1, "R7 third good");
    check("R5 locked after three", int'(lock_all), 1);

    // R6: wake ch1 (unlocked) while ch0 locked
    set_sleep(1, 1'b0);
    check("R6 ch1 awake unlocked", int'(lock_all), 0);
    pol_v[1] = 1'b0;
    cmp(1, 0, 0, "R2 ch1");
    cmp(1, -1, 1, "R1 ch1 pol0");
    cmp(1, 1, 1, "R1 ch1 pol0");
    check("R6 both locked", int'(lock_all), 1);
    cmp(1, 3, 3, "R4 ch1 large error");
    check("R4 ch1 drop", int'(lock_all), 0);

    // R9: monitor select sweep
    set_sleep(0, 1'b1);
    set_sleep(1, 1'b1);
    check("R9 lock route", int'(mon_out), 1);
    mon_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        mon_band = s[0];
        mon_src  = s[1];
        fr_v = {k == 1, k == 0};
        fp_v = {k == 3, k == 2};
        @(negedge clk);
        check($sformatf("R9 sel=%0d src=%0d", s, k), int'(mon_out), (s == k) ? 1 : 0);
        fr_v = '0;
        fp_v = '0;
        idle(1);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule